// File: doc/BRIEF.md
# Timer Interrupt Flag Register

This block holds the interrupt flags of a timer/counter with match/capture channels. The counter logic runs on its own clock and produces one-cycle event strobes: overflow, retrigger, counter event, five fault conditions, a ramp step and one match-or-capture strobe per channel. Each strobe is carried into the bus clock domain by a toggle synchronizer. Once it arrives, it sets a sticky flag in a 32-bit register that software reads and clears by writing ones.

Each channel has a mode input that marks it as capture or compare. A channel in capture mode has its flag cleared by a read strobe from its capture register. A capture that arrives while the channel flag is still set is an overrun and raises the error flag. A registered interrupt line is the OR of all flags gated by a 32-bit enable mask. The bus fabric decodes the register address and presents a plain write strobe to this block. The flag word is always visible on the read port.

Top module: `tc_irq_flags`

## Requirements
- R1: While reset is asserted and immediately after it, every bit of `rdData` reads 0 and `irqOut` is 0.
- R2: Each counter-domain strobe sets its own flag bit:
  - overflow sets bit 0, retrigger bit 1, counter event bit 2;
  - debug fault sets bit 11, recoverable fault A bit 12, recoverable fault B bit 13, non-recoverable fault 0 bit 14, non-recoverable fault 1 bit 15;
  - channel c sets bit 16+c.
  
  A flag stays set until it is cleared.
- R3: A write with `wrEn` high clears every implemented flag whose `wrData` bit is 1. Flags whose `wrData` bit is 0 keep their value, so a write of all zeros changes nothing.
- R4: Bits 9:4, and bits 31:16+NCH, always read 0, even after all ones are written and every event fires.
- R5: If a flag's set event and its clear land in the same bus cycle, the flag ends the cycle set.
- R6: A `capRead` strobe on a channel whose `chCapMode` bit is 1 (capture) clears that channel's flag on the next bus edge. On a channel in compare mode (`chCapMode` bit 0) the strobe has no effect.
- R7: The error flag (bit 3) is set when a capture-mode channel receives a new event while its flag is 1. Neither a first capture nor repeated events on a compare-mode channel set it.
- R8: The update fault flag (bit 10) is set by a `rampStep` strobe only while `lockUpdate` is 1. A ramp step with `lockUpdate` at 0 sets nothing.
- R9: `irqOut` equals the OR of (flags AND `irqEnable`) as they stood one bus cycle earlier.
- R10: With both clocks driven from one source, an event sampled at counter edge E appears on `rdData` at bus edge E+SYNC_STAGES+1 and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| busClk | input | 1 | Register bus clock |
| busRstN | input | 1 | Active-low asynchronous reset, bus domain |
| cntClk | input | 1 | Counter clock |
| cntRstN | input | 1 | Active-low asynchronous reset, counter domain |
| evOverflow | input | 1 | Overflow strobe (counter domain) |
| evRetrigger | input | 1 | Retrigger strobe (counter domain) |
| evCount | input | 1 | Counter event strobe (counter domain) |
| evFaultNr1 | input | 1 | Non-recoverable fault 1 strobe |
| evFaultNr0 | input | 1 | Non-recoverable fault 0 strobe |
| evFaultRecB | input | 1 | Recoverable fault B strobe |
| evFaultRecA | input | 1 | Recoverable fault A strobe |
| evDebugFault | input | 1 | Debug fault strobe |
| rampStep | input | 1 | Ramp index change strobe |
| lockUpdate | input | 1 | Lock-update control level (counter domain) |
| chEvent | input | NCH | Per-channel match/capture strobe (counter domain) |
| chCapMode | input | NCH | Per-channel mode, 1 = capture, 0 = compare (bus domain) |
| capRead | input | NCH | Per-channel capture-register read strobe (bus domain) |
| wrEn | input | 1 | Write strobe for the flag register |
| wrData | input | 32 | Write data; ones clear flags |
| irqEnable | input | 32 | Per-bit interrupt enable mask |
| rdData | output | 32 | Current flag word |
| irqOut | output | 1 | Registered combined interrupt |

## Verification
The bench builds the block with NCH = 8 and SYNC_STAGES = 2, and drives both clock inputs from one 250 MHz source. NCH = 8 fills every channel bit up to bit 23, so the boundary between channel bits and the always-zero upper bits is exercised. The shared clock makes the crossing latency exact, which lets the bench place a software clear in the very cycle a synchronized set arrives. It can also confirm that a flag is still clear one cycle before its expected arrival.

// File: rtl/tc_irq_flags_pkg.sv
package tc_irq_flags_pkg;

  // Flag bit positions inside the 32-bit word
  localparam int BIT_OVF  = 0;
  localparam int BIT_TRG  = 1;
  localparam int BIT_CNT  = 2;
  localparam int BIT_ERR  = 3;
  localparam int BIT_UPD  = 10;
  localparam int BIT_DBG  = 11;
  localparam int BIT_RFA  = 12;
  localparam int BIT_RFB  = 13;
  localparam int BIT_NRF0 = 14;
  localparam int BIT_NRF1 = 15;
  localparam int BIT_CH0  = 16;

  // Number of non-channel event sources entering the synchronizer
  localparam int NFIXED = 9;

  typedef struct packed {
    logic [31:0] setMask;
    logic [31:0] clrMask;
  } flagStrobes_t;

  function automatic logic [31:0] implMask(input int nch);
    logic [31:0] m;
    m = 32'h0000_FC0F;
    for (int i = 0; i < nch; i++) m[BIT_CH0 + i] = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/tc_irq_evt_sync.sv
module tc_irq_evt_sync #(
  parameter int N           = 17,
  parameter int SYNC_STAGES = 2
) (
  input  logic         srcClk,
  input  logic         srcRstN,
  input  logic [N-1:0] srcPulse,
  input  logic         dstClk,
  input  logic         dstRstN,
  output logic [N-1:0] dstPulse
);

  for (genvar i = 0; i < N; i++) begin : g_lane
    logic srcToggle;
    logic [SYNC_STAGES:0] dstShift;

    always_ff @(posedge srcClk or negedge srcRstN) begin
      if (!srcRstN) srcToggle <= 1'b0;
      else if (srcPulse[i]) srcToggle <= ~srcToggle;
    end

    always_ff @(posedge dstClk or negedge dstRstN) begin
      if (!dstRstN) dstShift <= '0;
      else dstShift <= {dstShift[SYNC_STAGES-1:0], srcToggle};
    end

    // Edge of the synchronized toggle marks one event
    assign dstPulse[i] = dstShift[SYNC_STAGES-1] ^ dstShift[SYNC_STAGES];
  end

endmodule

// File: rtl/tc_irq_ctrl.sv
module tc_irq_ctrl
  import tc_irq_flags_pkg::*;
#(
  parameter int NCH = 8,
  localparam int NSRC = NFIXED + NCH
) (
  input  logic [NSRC-1:0] syncEv,
  input  logic            wrEn,
  input  logic [31:0]     wrData,
  input  logic [NCH-1:0]  capRead,
  input  logic [NCH-1:0]  chCapMode,
  input  logic [NCH-1:0]  chFlags,
  output flagStrobes_t    strobes
);

  localparam logic [31:0] IMPL = implMask(NCH);

  logic [NCH-1:0] capEv;
  assign capEv = syncEv[NFIXED +: NCH];

  always_comb begin
    strobes.setMask = '0;
    strobes.setMask[BIT_OVF]  = syncEv[0];
    strobes.setMask[BIT_TRG]  = syncEv[1];
    strobes.setMask[BIT_CNT]  = syncEv[2];
    strobes.setMask[BIT_DBG]  = syncEv[3];
    strobes.setMask[BIT_RFA]  = syncEv[4];
    strobes.setMask[BIT_RFB]  = syncEv[5];
    strobes.setMask[BIT_NRF0] = syncEv[6];
    strobes.setMask[BIT_NRF1] = syncEv[7];
    strobes.setMask[BIT_UPD]  = syncEv[8];
    for (int c = 0; c < NCH; c++) strobes.setMask[BIT_CH0 + c] = capEv[c];
    // Overrun: capture arrives while its channel flag is still pending
    strobes.setMask[BIT_ERR] = |(capEv & chCapMode & chFlags);

    strobes.clrMask = wrEn ? wrData : 32'h0;
    for (int c = 0; c < NCH; c++)
      strobes.clrMask[BIT_CH0 + c] = strobes.clrMask[BIT_CH0 + c] | (capRead[c] & chCapMode[c]);
    strobes.clrMask = strobes.clrMask & IMPL;
  end

endmodule

// File: rtl/tc_irq_flags_dp.sv
module tc_irq_flags_dp
  import tc_irq_flags_pkg::*;
#(
  parameter int NCH = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  flagStrobes_t strobes,
  input  logic [31:0]  irqEnable,
  output logic [31:0]  flags,
  output logic         irqOut
);

  localparam logic [31:0] IMPL = implMask(NCH);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flags  <= '0;
      irqOut <= 1'b0;
    end else begin
      // Set has priority over clear
      flags  <= ((flags & ~strobes.clrMask) | strobes.setMask) & IMPL;
      irqOut <= |(flags & irqEnable);
    end
  end

endmodule

// File: rtl/tc_irq_flags.sv
module tc_irq_flags
  import tc_irq_flags_pkg::*;
#(
  parameter int NCH         = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic            busClk,
  input  logic            busRstN,
  input  logic            cntClk,
  input  logic            cntRstN,
  input  logic            evOverflow,
  input  logic            evRetrigger,
  input  logic            evCount,
  input  logic            evFaultNr1,
  input  logic            evFaultNr0,
  input  logic            evFaultRecB,
  input  logic            evFaultRecA,
  input  logic            evDebugFault,
  input  logic            rampStep,
  input  logic            lockUpdate,
  input  logic [NCH-1:0]  chEvent,
  input  logic [NCH-1:0]  chCapMode,
  input  logic [NCH-1:0]  capRead,
  input  logic            wrEn,
  input  logic [31:0]     wrData,
  input  logic [31:0]     irqEnable,
  output logic [31:0]     rdData,
  output logic            irqOut
);

  localparam int NSRC = NFIXED + NCH;

  logic [NSRC-1:0] srcVec;
  logic [NSRC-1:0] syncEv;
  flagStrobes_t    strobes;
  logic [31:0]     flags;

  assign srcVec = {chEvent, rampStep & lockUpdate, evFaultNr1, evFaultNr0,
                   evFaultRecB, evFaultRecA, evDebugFault, evCount,
                   evRetrigger, evOverflow};

  tc_irq_evt_sync #(.N(NSRC), .SYNC_STAGES(SYNC_STAGES)) u_sync (
    .srcClk  (cntClk),
    .srcRstN (cntRstN),
    .srcPulse(srcVec),
    .dstClk  (busClk),
    .dstRstN (busRstN),
    .dstPulse(syncEv)
  );

  tc_irq_ctrl #(.NCH(NCH)) u_ctrl (
    .syncEv   (syncEv),
    .wrEn     (wrEn),
    .wrData   (wrData),
    .capRead  (capRead),
    .chCapMode(chCapMode),
    .chFlags  (flags[BIT_CH0 +: NCH]),
    .strobes  (strobes)
  );

  tc_irq_flags_dp #(.NCH(NCH)) u_dp (
    .clk      (busClk),
    .rstN     (busRstN),
    .strobes  (strobes),
    .irqEnable(irqEnable),
    .flags    (flags),
    .irqOut   (irqOut)
  );

  assign rdData = flags;

endmodule

// File: rtl/tc_irq_flags_chk.sv
module tc_irq_flags_chk
  import tc_irq_flags_pkg::*;
#(
  parameter int NCH = 8
) (
  input logic           busClk,
  input logic           busRstN,
  input logic           wrEn,
  input logic [31:0]    wrData,
  input logic [NCH-1:0] capRead,
  input logic [NCH-1:0] chCapMode,
  input logic [31:0]    irqEnable,
  input logic [31:0]    rdData,
  input logic           irqOut
);

  localparam logic [31:0] IMPL = implMask(NCH);

  logic           armed;
  logic [31:0]    prevFlags, prevClr, prevEn, clrNow;
  logic [NCH-1:0] prevMode;

  always_comb begin
    clrNow = wrEn ? wrData : 32'h0;
    for (int c = 0; c < NCH; c++)
      clrNow[BIT_CH0 + c] = clrNow[BIT_CH0 + c] | (capRead[c] & chCapMode[c]);
  end

  always_ff @(posedge busClk or negedge busRstN) begin
    if (!busRstN) begin
      armed     <= 1'b0;
      prevFlags <= '0;
      prevClr   <= '0;
      prevEn    <= '0;
      prevMode  <= '0;
    end else begin
      armed     <= 1'b1;
      prevFlags <= rdData;
      prevClr   <= clrNow;
      prevEn    <= irqEnable;
      prevMode  <= chCapMode;
    end
  end

  a_r4_unimpl_zero: assert property (@(posedge busClk) disable iff (!busRstN)
    ((rdData & ~IMPL) == 32'h0));

  a_r9_irq_registered: assert property (@(posedge busClk) disable iff (!busRstN)
    armed |-> (irqOut == |(prevFlags & prevEn)));

  a_r3_clear_needs_one: assert property (@(posedge busClk) disable iff (!busRstN)
    armed |-> ((prevFlags & ~rdData & ~prevClr) == 32'h0));

  a_r7_err_needs_overrun: assert property (@(posedge busClk) disable iff (!busRstN)
    (armed && rdData[BIT_ERR] && !prevFlags[BIT_ERR]) |->
      (|(prevFlags[BIT_CH0 +: NCH] & prevMode)));

endmodule

bind tc_irq_flags tc_irq_flags_chk #(.NCH(NCH)) u_chk (
  .busClk   (busClk),
  .busRstN  (busRstN),
  .wrEn     (wrEn),
  .wrData   (wrData),
  .capRead  (capRead),
  .chCapMode(chCapMode),
  .irqEnable(irqEnable),
  .rdData   (rdData),
  .irqOut   (irqOut)
);

// File: tb/tc_irq_flags_bench.sv
module tc_irq_flags_bench;

  localparam int NCH = 8;
  localparam int NVEC = 13;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;

  logic [17:0]    stim = '0;  // [7:0] ch, 8 ovf, 9 trg, 10 cnt, 11 nrf1, 12 nrf0, 13 rfB, 14 rfA, 15 dbg, 16 ramp, 17 lock
  logic [NCH-1:0] chCapMode = '0;
  logic [NCH-1:0] capRead = '0;
  logic           wrEn = 1'b0;
  logic [31:0]    wrData = '0;
  logic [31:0]    irqEnable = '0;
  logic [31:0]    rdData;
  logic           irqOut;

  int checks = 0;
  int failures = 0;

  tc_irq_flags #(.NCH(NCH), .SYNC_STAGES(2)) u_tc_irq_flags (
    .busClk(clk), .busRstN(rstN), .cntClk(clk), .cntRstN(rstN),
    .evOverflow(stim[8]), .evRetrigger(stim[9]), .evCount(stim[10]),
    .evFaultNr1(stim[11]), .evFaultNr0(stim[12]), .evFaultRecB(stim[13]),
    .evFaultRecA(stim[14]), .evDebugFault(stim[15]),
    .rampStep(stim[16]), .lockUpdate(stim[17]),
    .chEvent(stim[7:0]), .chCapMode(chCapMode), .capRead(capRead),
    .wrEn(wrEn), .wrData(wrData), .irqEnable(irqEnable),
    .rdData(rdData), .irqOut(irqOut)
  );

  // {stimulus, expected flag word}
  localparam logic [49:0] VEC [NVEC] = '{
    {18'h00100, 32'h0000_0001}, {18'h00200, 32'h0000_0002},
    {18'h00400, 32'h0000_0004}, {18'h00800, 32'h0000_8000},
    {18'h01000, 32'h0000_4000}, {18'h02000, 32'h0000_2000},
    {18'h04000, 32'h0000_1000}, {18'h08000, 32'h0000_0800},
    {18'h30000, 32'h0000_0400}, {18'h10000, 32'h0000_0000},
    {18'h00001, 32'h0001_0000}, {18'h00080, 32'h0080_0000},
    {18'h00108, 32'h0008_0001}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  // Event driven for one counter cycle; returns at the negedge after the flag edge
  task automatic fire(input logic [17:0] v);
    @(negedge clk) stim = v;
    @(negedge clk) stim = '0;
    repeat (3) @(negedge clk);
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk) begin wrEn = 1'b1; wrData = d; end
    @(negedge clk) begin wrEn = 1'b0; wrData = '0; end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%08h expected=%08h", 32'h0, 32'h1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset flags", rdData, 32'h0);
    check("R1 reset irq", {31'h0, irqOut}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after reset", rdData, 32'h0);

    // Table walk: set, write zero (no effect), write one (clear)
    for (int i = 0; i < NVEC; i++) begin
      fire(VEC[i][49:32]);
      check("R2/R8 set", rdData, VEC[i][31:0]);
      wr(32'h0);
      check("R3 write zero", rdData, VEC[i][31:0]);
      wr(VEC[i][31:0]);
      check("R3 write one", rdData, 32'h0);
    end

    // R4: all ones written and every source fired
    wr(32'hFFFF_FFFF);
    check("R4 write ones on empty", rdData, 32'h0);
    fire(18'h3FFFF);
    check("R4 all sources", rdData, 32'h00FF_FC07);
    wr(32'hFFFF_FFFF);
    check("R3 clear all", rdData, 32'h0);

    // R10 exact latency
    @(negedge clk) stim = 18'h00100;
    @(negedge clk) stim = '0;
    repeat (2) @(negedge clk);
    check("R10 not yet", rdData, 32'h0);
    @(negedge clk);
    check("R10 arrived", rdData, 32'h1);

    // R5 collision: flag already set, clear lands with a new set
    @(negedge clk) stim = 18'h00100;
    @(negedge clk) stim = '0;
    @(negedge clk);
    @(negedge clk) begin wrEn = 1'b1; wrData = 32'h1; end
    @(negedge clk) begin wrEn = 1'b0; wrData = '0; end
    check("R5 set wins", rdData, 32'h1);
    wr(32'h1);
    check("R5 later clear", rdData, 32'h0);

    // R9 interrupt output
    irqEnable = 32'h0000_0004;
    fire(18'h00100);
    @(negedge clk);
    check("R9 masked", {31'h0, irqOut}, 32'h0);
    fire(18'h00400);
    check("R9 not yet", {31'h0, irqOut}, 32'h0);
    @(negedge clk);
    check("R9 raised", {31'h0, irqOut}, 32'h1);
    wr(32'h5);
    check("R9 held one cycle", {31'h0, irqOut}, 32'h1);
    @(negedge clk);
    check("R9 dropped", {31'h0, irqOut}, 32'h0);
    irqEnable = '0;

    // R6/R7 capture channel 2
    chCapMode = 8'h04;
    fire(18'h00004);
    check("R7 first capture no err", rdData, 32'h0004_0000);
    fire(18'h00004);
    check("R7 overrun err", rdData, 32'h0004_0008);
    @(negedge clk) capRead = 8'h04;
    @(negedge clk) capRead = '0;
    check("R6 capture read clears", rdData, 32'h0000_0008);
    wr(32'h8);
    check("R3 err cleared", rdData, 32'h0);

    // Compare-mode channel 5
    chCapMode = 8'h00;
    fire(18'h00020);
    fire(18'h00020);
    check("R7 compare no err", rdData, 32'h0020_0000);
    @(negedge clk) capRead = 8'h20;
    @(negedge clk) capRead = '0;
    check("R6 compare read ignored", rdData, 32'h0020_0000);
    wr(32'hFFFF_FFFF);
    check("R3 final clear", rdData, 32'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule